// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block turns two encoder lines, A and B, into a position count. A two-bit function field picks one of four ways of counting: four-times quadrature decoding, pulse with a direction level, increment only, or decrement only. Both encoder lines are resynchronised to the block clock before their edges are examined.

The count lives between zero and a programmable ceiling and wraps at either end. A control bit gates counting. Software reaches the count, the ceiling and two 16-bit control words through a small single-cycle register port. Reads are combinational and writes complete on the clock edge. A software load of the count is refused when the value is above the ceiling.

Top module: `qpos_counter`

## Requirements
- R1: After reset the count reads 0, the ceiling reads 0xFFFFFFFF, both control words read 0, `phase_err` is low, and an unmapped address reads 0.
- R2: The register map uses byte offsets. Offset 0x00 holds the count and offset 0x08 holds the ceiling. Offset 0x28 holds the decoder control word and offset 0x2A holds the main control word. The 16-bit words use wdata[15:0] and read back zero-extended.
- R3: When decoder control bits 15:14 equal 0, quadrature mode is selected. The sequence AB 00→01→11→10→00 adds one per step and the reverse sequence subtracts one per step.
- R4: In quadrature mode, a change of both A and B within one sampled step leaves the count unchanged. It also raises `phase_err` for one cycle.
- R5: When bits 15:14 equal 1, direction-count mode is selected. Only a rising edge of A counts: up when B is high, down when B is low. Edges of B and falling edges of A do not change the count.
- R6: When bits 15:14 equal 2, the block counts up, and when they equal 3, it counts down. In both modes B is ignored. With decoder control bit 11 clear, only rising edges of A count. With bit 11 set, both edges of A count.
- R7: While main control bit 3 is clear, the count holds its value.
- R8: Counting up from the ceiling gives 0, and counting down from 0 gives the ceiling.
- R9: A count write at or below the ceiling loads the value and wins over a count event in the same cycle. A count write above the ceiling is ignored.
- R10: An input change sampled at clock edge k is reflected in the count after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder line A (asynchronous) |
| enc_b | input | 1 | Encoder line B (asynchronous) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| phase_err | output | 1 | One-cycle pulse on an illegal quadrature step |

## Verification
The embedded properties check four things on every cycle: the count stays frozen while counting is disabled, it stays frozen on an illegal quadrature step, B alone never moves it in direction-count mode, and it never falls in increment mode below the ceiling. The bench scenarios are the only check of the exact count values in each mode, the wrap values at both ends, the refusal of loads above the ceiling, the priority of a load over a simultaneous edge, and the two-edge latency from a sampled input to the count.

// File: rtl/qpos_counter.sv
module qpos_counter #(
  parameter int AW = 6,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          phase_err
);
  localparam logic [AW-1:0] A_POS  = AW'(8'h00);
  localparam logic [AW-1:0] A_CEIL = AW'(8'h08);
  localparam logic [AW-1:0] A_DEC  = AW'(8'h28);
  localparam logic [AW-1:0] A_CTL  = AW'(8'h2A);

  logic [CW-1:0] pos, ceil;
  logic [15:0]   dec_ctl, main_ctl;
  logic [1:0]    a_sync, b_sync;
  logic          a_prev, b_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sync <= '0; b_sync <= '0; a_prev <= 1'b0; b_prev <= 1'b0;
    end else begin
      a_sync <= {a_sync[0], enc_a};
      b_sync <= {b_sync[0], enc_b};
      a_prev <= a_sync[1];
      b_prev <= b_sync[1];
    end
  end

  wire       a_cur   = a_sync[1];
  wire       b_cur   = b_sync[1];
  wire [1:0] mode    = dec_ctl[15:14];
  wire       both_ed = dec_ctl[11];
  wire       cnt_en  = main_ctl[3];
  wire       a_rise  = a_cur & ~a_prev;
  wire       a_fall  = ~a_cur & a_prev;
  wire       a_edge  = a_rise | a_fall;
  wire [1:0] ab_old  = {a_prev, b_prev};
  wire [1:0] ab_new  = {a_cur, b_cur};
  wire       dbl_chg = (a_cur != a_prev) && (b_cur != b_prev);

  logic q_up, q_dn;
  always_comb begin
    q_up = 1'b0;
    q_dn = 1'b0;
    unique case (ab_old)
      2'b00: begin q_up = (ab_new == 2'b01); q_dn = (ab_new == 2'b10); end
      2'b01: begin q_up = (ab_new == 2'b11); q_dn = (ab_new == 2'b00); end
      2'b11: begin q_up = (ab_new == 2'b10); q_dn = (ab_new == 2'b01); end
      2'b10: begin q_up = (ab_new == 2'b00); q_dn = (ab_new == 2'b11); end
    endcase
  end

  logic inc, dec;
  always_comb begin
    inc = 1'b0;
    dec = 1'b0;
    unique case (mode)
      2'd0: begin inc = q_up; dec = q_dn; end
      2'd1: begin inc = a_rise & b_cur; dec = a_rise & ~b_cur; end
      2'd2: inc = both_ed ? a_edge : a_rise;
      2'd3: dec = both_ed ? a_edge : a_rise;
    endcase
  end

  wire pos_wr = bus_we && (bus_addr == A_POS) && (CW'(bus_wdata) <= ceil);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      ceil <= '1;
      dec_ctl <= '0;
      main_ctl <= '0;
      phase_err <= 1'b0;
    end else begin
      phase_err <= (mode == 2'd0) && dbl_chg;
      if (bus_we && bus_addr == A_CEIL) ceil <= CW'(bus_wdata);
      if (bus_we && bus_addr == A_DEC) dec_ctl <= bus_wdata[15:0];
      if (bus_we && bus_addr == A_CTL) main_ctl <= bus_wdata[15:0];
      if (pos_wr) pos <= CW'(bus_wdata);
      else if (cnt_en && inc) pos <= (pos == ceil) ? '0 : pos + 1'b1;
      else if (cnt_en && dec) pos <= (pos == '0) ? ceil : pos - 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_POS:   bus_rdata = 32'(pos);
      A_CEIL:  bus_rdata = 32'(ceil);
      A_DEC:   bus_rdata = {16'h0, dec_ctl};
      A_CTL:   bus_rdata = {16'h0, main_ctl};
      default: bus_rdata = '0;
    endcase
  end

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !pos_wr) |=> $stable(pos));
  // R4
  phase_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && dbl_chg && !pos_wr) |=> $stable(pos));
  // R5
  b_level_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && a_cur == a_prev && !pos_wr) |=> $stable(pos));
  // R6
  up_never_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !pos_wr && pos < ceil) |=> pos >= $past(pos));
  // R4
  phase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |-> $past(mode) == 2'd0);
endmodule

// File: tb/sim_qpos_counter.sv
module sim_qpos_counter;
  logic clk = 1'b0, rst_n = 1'b0, enc_a = 1'b0, enc_b = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic phase_err;
  int checks = 0, errors = 0, pe_seen = 0;
  bit done = 1'b0;

  qpos_counter u0 (.clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .phase_err(phase_err));

  always #5 clk = ~clk;
  always @(posedge clk) if (phase_err) pe_seen++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic ab(input logic a, input logic b);
    @(negedge clk); enc_a = a; enc_b = b;
    repeat (4) @(posedge clk);
  endtask

  task automatic pos_is(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(6'h00, v); check(tag, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h00, v); check("R1 count", v, 0);
    rd(6'h08, v); check("R1 ceiling", v, 32'hFFFF_FFFF);
    rd(6'h28, v); check("R1 decctl", v, 0);
    rd(6'h2A, v); check("R1 mainctl", v, 0);
    rd(6'h04, v); check("R1 unmapped", v, 0);
    check("R1 phase_err", phase_err, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(6'h08, 100);      rd(6'h08, v); check("R2 ceiling", v, 100);
    wr(6'h28, 32'hABCD_4800); rd(6'h28, v); check("R2 decctl", v, 32'h4800);
    wr(6'h28, 0);
    wr(6'h2A, 32'h0000_0008); rd(6'h2A, v); check("R2 mainctl", v, 8);
    wr(6'h00, 10); pos_is("R2 count load", 10);
  endtask

  task automatic t_quad;
    ab(0, 1); ab(1, 1); ab(1, 0); ab(0, 0);
    pos_is("R3 quad up x4", 14);
    ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
    pos_is("R3 quad down x4", 10);
    pe_seen = 0;
    ab(1, 1); pos_is("R4 double step no count", 10);
    ab(0, 0); pos_is("R4 double step back", 10);
    check("R4 phase_err pulses", pe_seen, 2);
  endtask

  task automatic t_dir;
    wr(6'h28, 32'h4000);
    ab(0, 1); pos_is("R5 B edge ignored", 10);
    ab(1, 1); pos_is("R5 A rise B high up", 11);
    ab(0, 1); pos_is("R5 A fall ignored", 11);
    ab(0, 0); pos_is("R5 B fall ignored", 11);
    ab(1, 0); pos_is("R5 A rise B low down", 10);
    ab(0, 0);
  endtask

  task automatic t_updown;
    wr(6'h28, 32'h8000);
    ab(1, 0); pos_is("R6 up rising", 11);
    ab(0, 0); pos_is("R6 up falling ignored", 11);
    ab(0, 1); ab(0, 0); pos_is("R6 up B ignored", 11);
    wr(6'h28, 32'h8800);
    ab(1, 0); ab(0, 0); pos_is("R6 up both edges", 13);
    wr(6'h28, 32'hC000);
    ab(1, 0); ab(0, 0); pos_is("R6 down rising", 12);
    wr(6'h28, 32'hC800);
    ab(1, 0); ab(0, 0); pos_is("R6 down both edges", 10);
  endtask

  task automatic t_wrap;
    wr(6'h28, 32'h8000); wr(6'h00, 100);
    ab(1, 0); ab(0, 0); pos_is("R8 wrap at ceiling", 0);
    wr(6'h28, 32'hC000);
    ab(1, 0); ab(0, 0); pos_is("R8 wrap below zero", 100);
  endtask

  task automatic t_enable;
    wr(6'h28, 32'h8800); wr(6'h00, 20); wr(6'h2A, 0);
    ab(1, 1); ab(0, 0); pos_is("R7 disabled hold", 20);
    wr(6'h2A, 8);
  endtask

  task automatic t_write;
    wr(6'h00, 101); pos_is("R9 above ceiling ignored", 20);
    wr(6'h00, 100); pos_is("R9 at ceiling loads", 100);
    wr(6'h28, 32'h8000); wr(6'h00, 30);
    @(negedge clk); enc_a = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 6'h00; bus_wdata = 50;
    @(negedge clk); bus_we = 1'b0;
    pos_is("R9 write beats count", 50);
    @(negedge clk); enc_a = 1'b0; repeat (4) @(posedge clk);
  endtask

  task automatic t_latency;
    @(negedge clk); enc_a = 1'b1;
    @(posedge clk); @(posedge clk);
    pos_is("R10 unchanged after two edges", 50);
    pos_is("R10 updated after third edge", 51);
    @(negedge clk); enc_a = 1'b0; repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset; t_regs; t_quad; t_dir; t_updown; t_wrap; t_enable; t_write; t_latency;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule